// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block decides how a small processor core is clocked. A control register holds an idle-enable flag and a two-bit clock-source select field. From that register, a sleep-instruction strobe, a wake event and the ready flags of three oscillators, the controller drives a clock enable for the CPU and one for the peripherals. It also drives a select for an external clock multiplexer and a 3-bit code that names the current mode. There are seven modes: a Run mode and an Idle mode for each of the three sources (primary, secondary timer oscillator, internal oscillator block), and one Sleep mode.

While the core runs, software writes the select field to change the clock source. The controller moves the multiplexer to the requested source only once that source reports ready, and flags a pending switch until then. A sleep-instruction strobe stops the clocks. The idle-enable flag, as it stands when the strobe arrives, decides between Idle (peripherals keep running) and Sleep (everything stops). A wake event brings the core back to the Run mode that the select field names, and only after that source is ready.

Top module: `pmm_ctrl`

## Requirements
- R1: A synchronous reset gives the PRI_RUN mode (code 1), both clock enables high, source select 0, idle flag 0, select field 00 and no pending switch.
- R2: A register write takes the idle-enable flag from bit 7 and the select field from bits 1:0. Field 00 requests the primary source (mux select 0), 01 the secondary source (mux select 1), and 10 or 11 the internal block (mux select 2).
- R3: In a Run mode both clock enables are high, and the mode code is 1, 2 or 3 for the primary, secondary or internal source.
- R4: When the requested source differs from the active one and is ready, the pending flag is high for one cycle and the mux select takes the new value at the following clock edge.
- R5: While the requested source is not ready, the active source is kept and the pending flag stays high. The mux select changes at the first clock edge that sees the ready flag high.
- R6: A sleep strobe in a Run mode with the idle flag at 1 gives Idle from the next cycle: CPU enable low, peripheral enable high, mode code 4, 5 or 6 for the primary, secondary or internal source.
- R7: A sleep strobe in a Run mode with the idle flag at 0 gives Sleep from the next cycle: both enables low and mode code 0.
- R8: The idle flag is sampled only at the sleep strobe. A register write in the same cycle as the strobe does not change the outcome, and writing the flag while in Run leaves the clocks unchanged.
- R9: A wake event in Idle or Sleep returns to the Run mode of the select field when that source is ready. If it is not ready, both enables stay low and the mode code is 0 until it becomes ready.
- R10: A wake event in a Run mode has no effect, and a sleep strobe in Idle, Sleep or while waiting to wake has no effect.
- R11: The mode code is never 7, and the CPU enable is never high while the peripheral enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| sleep_exec | input | 1 | Sleep instruction executed strobe |
| wake | input | 1 | Wake event |
| pri_rdy | input | 1 | Primary oscillator ready |
| sec_rdy | input | 1 | Secondary oscillator ready |
| int_rdy | input | 1 | Internal oscillator block ready |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| src_sel | output | 2 | Clock mux select: 0 primary, 1 secondary, 2 internal |
| mode | output | 3 | Mode code: 0 Sleep, 1-3 Run, 4-6 Idle |
| switch_pending | output | 1 | Requested source differs from the active one |

## Verification
The assertions assume that every input is a known 0 or 1 at each clock edge and that reset is held from time zero through the first edges. They also assume that the ready flags can change in any cycle, so no property relies on a flag staying stable. The stimulus drives all inputs at the falling edge from defined values and holds reset high for several cycles before release. It then draws strobes and ready flags from a seeded generator. The ready flags are biased towards high so that waits and switches both finish, while the low draws still reach the pending and wake-wait paths.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int SRC_W  = 2;
  localparam int MODE_W = 3;
  localparam int NSRC   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pm_state_e;

  // select field to source: 00 primary, 01 secondary, 1x internal
  function automatic src_e sel_to_src(input logic [1:0] sel);
    if (sel[1])      return SRC_INT;
    else if (sel[0]) return SRC_SEC;
    else             return SRC_PRI;
  endfunction

  function automatic logic src_ready(input logic [NSRC-1:0] rdy, input src_e s);
    case (s)
      SRC_PRI: return rdy[0];
      SRC_SEC: return rdy[1];
      default: return rdy[2];
    endcase
  endfunction

  // 0 sleep/waiting, 1..3 run, 4..6 idle
  function automatic logic [MODE_W-1:0] mode_code(input pm_state_e st, input src_e s);
    case (st)
      ST_RUN:  return 3'd1 + {1'b0, s};
      ST_IDLE: return 3'd4 + {1'b0, s};
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pmm_ctrl_reg.sv
module pmm_ctrl_reg #(
  parameter int DATA_W   = 8,
  parameter int IDLE_POS = 7,
  parameter int SEL_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              idle_en,
  output logic [1:0]        sel
);
  localparam int SEL_MSB = SEL_LSB + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_en <= 1'b0;
      sel     <= 2'b00;
    end else if (we) begin
      idle_en <= wdata[IDLE_POS];
      sel     <= wdata[SEL_MSB:SEL_LSB];
    end
  end

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (idle_en == $past(wdata[IDLE_POS])) && (sel == $past(wdata[SEL_MSB:SEL_LSB])));
  // R8
  reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(idle_en) && $stable(sel));
endmodule

// File: rtl/pmm_src_switch.sv
module pmm_src_switch
  import pmm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            allow,
  input  src_e            req_src,
  input  logic [NSRC-1:0] rdy,
  output src_e            cur_src,
  output logic            req_ready,
  output logic            pending
);
  assign req_ready = src_ready(rdy, req_src);
  assign pending   = (req_src != cur_src);

  always_ff @(posedge clk) begin
    if (rst)                                 cur_src <= SRC_PRI;
    else if (allow && req_ready && pending)  cur_src <= req_src;
  end

  // R4
  switch_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_src != $past(cur_src)) |-> ($past(req_ready) && cur_src == $past(req_src)));
  // R5
  wait_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && !req_ready) |=> $stable(cur_src));
  // R2
  src_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cur_src != 2'd3);
endmodule

// File: rtl/pmm_mode_fsm.sv
module pmm_mode_fsm
  import pmm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_exec,
  input  logic      wake,
  input  logic      idle_en,
  input  logic      req_ready,
  output pm_state_e state,
  output logic      allow_switch
);
  pm_state_e nxt;
  logic      in_low_power;
  logic      sleep_ev;
  logic      wake_ev;

  assign in_low_power = (state == ST_IDLE) || (state == ST_SLEEP);
  assign sleep_ev     = (state == ST_RUN) && sleep_exec;
  assign wake_ev      = in_low_power && wake;
  assign allow_switch = (state == ST_RUN) || (state == ST_WAKE) || wake_ev;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:            if (sleep_exec) nxt = idle_en ? ST_IDLE : ST_SLEEP;
      ST_IDLE, ST_SLEEP: if (wake)       nxt = req_ready ? ST_RUN : ST_WAKE;
      default:           if (req_ready)  nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= nxt;
  end

  // R6
  idle_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_ev && idle_en) |=> state == ST_IDLE);
  // R7
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_ev && !idle_en) |=> state == ST_SLEEP);
  // R9
  wake_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (wake_ev && req_ready) |=> state == ST_RUN);
  // R10
  run_wake_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !sleep_exec) |=> state == ST_RUN);
  // R10
  lowpower_sleep_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (in_low_power && !wake) |=> $stable(state));
endmodule

// File: rtl/pmm_ctrl.sv
module pmm_ctrl
  import pmm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int IDLE_POS = 7,
  parameter int SEL_LSB  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              sleep_exec,
  input  logic              wake,
  input  logic              pri_rdy,
  input  logic              sec_rdy,
  input  logic              int_rdy,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic [SRC_W-1:0]  src_sel,
  output logic [MODE_W-1:0] mode,
  output logic              switch_pending
);
  logic            idle_en;
  logic [1:0]      sel_field;
  src_e            req_src;
  src_e            cur_src;
  logic            req_ready;
  logic            allow_switch;
  pm_state_e       state;
  logic [NSRC-1:0] rdy_vec;

  assign rdy_vec = {int_rdy, sec_rdy, pri_rdy};
  assign req_src = sel_to_src(sel_field);

  pmm_ctrl_reg #(.DATA_W(DATA_W), .IDLE_POS(IDLE_POS), .SEL_LSB(SEL_LSB)) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .idle_en(idle_en), .sel(sel_field)
  );

  pmm_src_switch u_sw (
    .clk(clk), .rst(rst), .allow(allow_switch), .req_src(req_src), .rdy(rdy_vec),
    .cur_src(cur_src), .req_ready(req_ready), .pending(switch_pending)
  );

  pmm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_exec(sleep_exec), .wake(wake), .idle_en(idle_en),
    .req_ready(req_ready), .state(state), .allow_switch(allow_switch)
  );

  assign cpu_clk_en = (state == ST_RUN);
  assign per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
  assign src_sel    = cur_src;
  assign mode       = mode_code(state, cur_src);

  // R11
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 3'd7);
  // R11
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> per_clk_en);
  // R3
  run_code_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (mode >= 3'd1 && mode <= 3'd3));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (mode == 3'd1 && src_sel == 2'd0 && !switch_pending));
endmodule

// File: tb/pmm_ctrl_tb.sv
module pmm_ctrl_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       sleep_exec = 1'b0;
  logic       wake = 1'b0;
  logic       pri_rdy = 1'b1;
  logic       sec_rdy = 1'b1;
  logic       int_rdy = 1'b1;
  logic       cpu_clk_en, per_clk_en, switch_pending;
  logic [1:0] src_sel;
  logic [2:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model: state 0 run, 1 idle, 2 sleep, 3 waiting to wake
  int m_st, m_cur, m_sel, m_idle;

  always #(CLK_P/2) clk = ~clk;

  pmm_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .sleep_exec(sleep_exec), .wake(wake), .pri_rdy(pri_rdy), .sec_rdy(sec_rdy),
    .int_rdy(int_rdy), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .src_sel(src_sel), .mode(mode), .switch_pending(switch_pending)
  );

  function automatic int field_src(int f);
    if (f >= 2) return 2;
    return f;
  endfunction

  function automatic int rdy_of(int s);
    if (s == 0) return int'(pri_rdy);
    if (s == 1) return int'(sec_rdy);
    return int'(int_rdy);
  endfunction

  function automatic int exp_mode();
    if (m_st == 0) return m_cur + 1;
    if (m_st == 1) return m_cur + 4;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " cpu_en"}, int'(cpu_clk_en), int'(m_st == 0));
    chk({tag, " per_en"}, int'(per_clk_en), int'(m_st <= 1));
    chk({tag, " src"}, int'(src_sel), m_cur);
    chk({tag, " mode"}, int'(mode), exp_mode());
    chk({tag, " pend"}, int'(switch_pending), int'(field_src(m_sel) != m_cur));
  endtask

  // one clock edge: update model with the inputs held across it
  task automatic step();
    int req;
    int ok;
    @(posedge clk);
    if (rst) begin
      m_st = 0; m_cur = 0; m_sel = 0; m_idle = 0;
    end else begin
      req = field_src(m_sel);
      ok  = rdy_of(req);
      if ((m_st == 0 || m_st == 3 || ((m_st == 1 || m_st == 2) && wake)) && ok != 0)
        m_cur = req;
      case (m_st)
        0: if (sleep_exec) m_st = (m_idle != 0) ? 1 : 2;
        1, 2: if (wake) m_st = (ok != 0) ? 0 : 3;
        default: if (ok != 0) m_st = 0;
      endcase
      if (reg_we) begin
        m_idle = int'(reg_wdata[7]);
        m_sel  = int'(reg_wdata[1:0]);
      end
    end
    @(negedge clk);
    reg_we = 1'b0; sleep_exec = 1'b0; wake = 1'b0;
  endtask

  task automatic wr(logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;
    check_all("R1");
    chk("R1 mode", int'(mode), 1);

    // R2/R3: secondary then internal
    wr(8'h01); step(); check_all("R2");
    step(); check_all("R3");
    chk("R3 sec mode", int'(mode), 2);
    wr(8'h02); step(); step(); check_all("R3");
    chk("R2 int src", int'(src_sel), 2);
    wr(8'h03); step(); step(); check_all("R2");
    chk("R2 1x int", int'(src_sel), 2);

    // R4: ready switch pulses pending once
    wr(8'h00); step();
    chk("R4 pend", int'(switch_pending), 1);
    check_all("R4");
    step(); check_all("R4");
    chk("R4 src", int'(src_sel), 0);

    // R5: secondary not ready
    sec_rdy = 1'b0; wr(8'h01);
    for (int i = 0; i < 4; i++) begin step(); check_all("R5"); end
    chk("R5 held", int'(src_sel), 0);
    sec_rdy = 1'b1; step(); check_all("R5");
    chk("R5 moved", int'(src_sel), 1);

    // R8/R6: idle set, strobe with same-cycle write clearing it
    wr(8'h81); step(); check_all("R8");
    sleep_exec = 1'b1; wr(8'h01); step(); check_all("R6");
    chk("R8 idle kept", int'(mode), 5);
    sleep_exec = 1'b1; step(); check_all("R10");
    wake = 1'b1; step(); check_all("R9");
    chk("R9 back run", int'(mode), 2);

    // R7 and wake wait
    sleep_exec = 1'b1; step(); check_all("R7");
    chk("R7 sleep", int'(mode), 0);
    sec_rdy = 1'b0; wake = 1'b1; step(); check_all("R9");
    sleep_exec = 1'b1; step(); check_all("R10");
    chk("R9 wait", int'(cpu_clk_en), 0);
    sec_rdy = 1'b1; step(); check_all("R9");
    chk("R9 resumed", int'(mode), 2);
    wake = 1'b1; step(); check_all("R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      reg_we     = ($urandom % 6) == 0;
      reg_wdata  = 8'($urandom);
      sleep_exec = ($urandom % 10) == 0;
      wake       = ($urandom % 4) == 0;
      pri_rdy    = ($urandom % 4) != 0;
      sec_rdy    = ($urandom % 3) != 0;
      int_rdy    = ($urandom % 4) != 0;
      step();
      check_all("R11 rand");
      chk("R11 code", int'(mode == 3'd7), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule